// File: doc/BRIEF.md
# Serial Peripheral Byte Register Port

This block is the register face of a two-channel serial peripheral on a simple synchronous processor bus. Every access is one byte wide and completes in the cycle it is presented: read data and the done pulse are produced combinationally from the address and strobes, and writes land at the next rising clock edge. Each channel has its own mode, status, command and clock-select location. The mode and clock-select bytes are held here and driven out to the serial logic. The status byte is read-only and comes in from that logic. The command location is write-only and turns a write into a one-cycle strobe.

Addresses that decode to nothing read as zero, and writes to them, or to the read-only status locations, are accepted and discarded. A vector register and an interrupt-enable bit sit beside the channel registers. The interrupt request is the pending input gated by that enable bit. When the processor runs an acknowledge cycle while this block is requesting, the block drives its vector onto the read data and signals done. The vector resets to the spurious value 0x0F, so a handler that never loaded it receives that value.

Top module: `sio_regport`

## Requirements
- R1: After reset, the mode and clock-select bytes of every channel read 0x00, the vector reads 0x0F, the enable location reads 0x00 and irq is low even with pend_in high.
- R2: done is high in the same cycle as any rd_en or wr_en, whatever the address, and low in a cycle with no strobe.
- R3: Channel c's mode byte is at address 8*c+0 and its clock-select byte is at 8*c+2 (c = 0, 1). Both are read/write, a write is readable from the next cycle, and the two channels do not affect each other.
- R4: Address 8*c+1 returns chan_status[8*c+7:8*c] in the same cycle; writes to it change nothing.
- R5: A write to address 8*c+3 raises cmd_wr[c] for that one cycle with cmd_data equal to wr_data; reading that address returns 0x00.
- R6: Reserved addresses (offsets 4 to 7 inside each channel block, and 0x12 to 0x1F) read 0x00, and writes to them change no register.
- R7: Address 0x10 is the read/write vector register; it changes only when written.
- R8: Address 0x11 holds the enable in bit 0; only bit 0 is stored and the other bits read 0. irq equals pend_in AND enable, in the same cycle, and falls as soon as pend_in falls.
- R9: When iack is high while irq is high, done is high and rd_data equals the vector in that cycle.
- R10: When iack is high while irq is low, and no read or write strobe is present, done stays low and rd_data is 0x00.
- R11: An acknowledge answered before the vector was ever written returns 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| iack | input | 1 | Interrupt-acknowledge strobe |
| pend_in | input | 1 | Interrupt pending from the serial logic |
| chan_status | input | 16 | Status byte per channel, channel 0 in the low byte |
| rd_data | output | 8 | Read or vector data |
| done | output | 1 | Cycle complete |
| irq | output | 1 | Interrupt request |
| cmd_wr | output | 2 | Command-write strobe per channel |
| cmd_data | output | 8 | Command byte |
| cfg_mode | output | 16 | Mode bytes per channel |
| cfg_clksel | output | 16 | Clock-select bytes per channel |

## Verification
rd_data, done, cmd_wr, cmd_data and irq are due in the same cycle as the strobe that causes them, with zero cycles of latency. A write becomes visible to a read one cycle later, after the one register it passes through. The driver applies each access one time unit after a rising edge and queues the expected values from its own register model. The monitor pops and compares them at the falling edge of that same cycle, so every comparison falls inside the cycle that produced it. The model takes each write into account only after the entry for that cycle has been queued, which matches the one-edge delay before a written value can be read back.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;
  localparam int CHW = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_MODE, RG_STAT, RG_CLKS, RG_CMD, RG_VEC, RG_IEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [CHW-1:0]   chan;
  } reg_sel_t;

  // offset inside one channel block -> register kind
  function automatic reg_kind_e chan_kind(input logic [CHW-1:0] off);
    case (off)
      4'd0:    return RG_MODE;
      4'd1:    return RG_STAT;
      4'd2:    return RG_CLKS;
      4'd3:    return RG_CMD;
      default: return RG_NONE;
    endcase
  endfunction

  // enable byte as seen on a read
  function automatic logic [7:0] ien_view(input logic ien);
    return {7'b0, ien};
  endfunction
endpackage

// File: rtl/sio_regport_dec.sv
module sio_regport_dec
  import sio_regport_pkg::*;
#(
  parameter int AW       = 5,
  parameter int NCH      = 2,
  parameter int STRIDE   = 8,
  parameter logic [AW-1:0] VEC_ADDR = 5'h10,
  parameter logic [AW-1:0] IEN_ADDR = 5'h11
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);
  localparam int LIMIT = NCH * STRIDE;

  always_comb begin
    sel.kind = RG_NONE;
    sel.chan = '0;
    if (addr == VEC_ADDR) begin
      sel.kind = RG_VEC;
    end else if (addr == IEN_ADDR) begin
      sel.kind = RG_IEN;
    end else if (int'(addr) < LIMIT) begin
      sel.chan = CHW'(int'(addr) / STRIDE);
      sel.kind = chan_kind(CHW'(int'(addr) % STRIDE));
    end
  end
endmodule

// File: rtl/sio_regport_chan.sv
module sio_regport_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_clks,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] clks_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      clks_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_clks) clks_q <= wdata;
    end
  end
endmodule

// File: rtl/sio_regport_vec.sv
module sio_regport_vec #(
  parameter int DW = 8,
  parameter logic [DW-1:0] VEC_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vec,
  input  logic          wr_ien,
  input  logic [DW-1:0] wdata,
  input  logic          pend_in,
  input  logic          iack,
  output logic [DW-1:0] vec_q,
  output logic          ien_q,
  output logic          irq,
  output logic          iack_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= VEC_RST;
      ien_q <= 1'b0;
    end else begin
      if (wr_vec) vec_q <= wdata;
      if (wr_ien) ien_q <= wdata[0];
    end
  end

  assign irq      = pend_in & ien_q;
  assign iack_hit = iack & irq;
endmodule

// File: rtl/sio_regport.sv
module sio_regport
  import sio_regport_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 8,
  parameter int NCH    = 2,
  parameter int STRIDE = 8,
  parameter logic [AW-1:0] VEC_ADDR = 5'h10,
  parameter logic [AW-1:0] IEN_ADDR = 5'h11,
  parameter logic [DW-1:0] VEC_RST  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              iack,
  input  logic              pend_in,
  input  logic [NCH*DW-1:0] chan_status,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              irq,
  output logic [NCH-1:0]    cmd_wr,
  output logic [DW-1:0]     cmd_data,
  output logic [NCH*DW-1:0] cfg_mode,
  output logic [NCH*DW-1:0] cfg_clksel
);
  reg_sel_t       sel;
  logic           rd_act, wr_act, iack_hit, ien_q;
  logic [DW-1:0]  vec_q, reg_word;
  logic [DW-1:0]  mode_w [NCH];
  logic [DW-1:0]  clks_w [NCH];
  logic [DW-1:0]  stat_w [NCH];

  // acknowledge outranks read, read outranks write
  assign rd_act = rd_en & ~iack;
  assign wr_act = wr_en & ~rd_en & ~iack;

  sio_regport_dec #(
    .AW(AW), .NCH(NCH), .STRIDE(STRIDE),
    .VEC_ADDR(VEC_ADDR), .IEN_ADDR(IEN_ADDR)
  ) dec_i (
    .addr(addr),
    .sel (sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (sel.chan == CHW'(c));
    assign stat_w[c] = chan_status[c*DW +: DW];

    sio_regport_chan #(.DW(DW)) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_mode(wr_act & hit & (sel.kind == RG_MODE)),
      .wr_clks(wr_act & hit & (sel.kind == RG_CLKS)),
      .wdata  (wr_data),
      .mode_q (mode_w[c]),
      .clks_q (clks_w[c])
    );

    assign cmd_wr[c]             = wr_act & hit & (sel.kind == RG_CMD);
    assign cfg_mode[c*DW +: DW]   = mode_w[c];
    assign cfg_clksel[c*DW +: DW] = clks_w[c];
  end

  assign cmd_data = wr_data;

  sio_regport_vec #(.DW(DW), .VEC_RST(VEC_RST)) vec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vec  (wr_act & (sel.kind == RG_VEC)),
    .wr_ien  (wr_act & (sel.kind == RG_IEN)),
    .wdata   (wr_data),
    .pend_in (pend_in),
    .iack    (iack),
    .vec_q   (vec_q),
    .ien_q   (ien_q),
    .irq     (irq),
    .iack_hit(iack_hit)
  );

  always_comb begin
    reg_word = '0;
    case (sel.kind)
      RG_VEC:  reg_word = vec_q;
      RG_IEN:  reg_word = ien_view(ien_q);
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (sel.chan == CHW'(c)) begin
            if (sel.kind == RG_MODE) reg_word = mode_w[c];
            if (sel.kind == RG_STAT) reg_word = stat_w[c];
            if (sel.kind == RG_CLKS) reg_word = clks_w[c];
          end
        end
      end
    endcase
  end

  assign rd_data = iack_hit ? vec_q : (rd_act ? reg_word : '0);
  assign done    = rd_en | wr_en | iack_hit;
endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk #(
  parameter int AW  = 5,
  parameter int DW  = 8,
  parameter int NCH = 2,
  parameter logic [AW-1:0] VEC_ADDR = 5'h10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  addr,
  input logic           rd_en,
  input logic           wr_en,
  input logic           iack,
  input logic           pend_in,
  input logic           irq,
  input logic           done,
  input logic [DW-1:0]  rd_data,
  input logic [DW-1:0]  vec_q,
  input logic           ien_q,
  input logic [NCH-1:0] cmd_wr
);
  p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> done);

  p_irq_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_in |-> !irq);

  p_irq_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq);

  p_iack_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq) |-> (done && rd_data == vec_q));

  p_iack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !irq && !rd_en && !wr_en) |-> (!done && rd_data == '0));

  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == VEC_ADDR) |=> $stable(vec_q));

  p_cmd_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_wr) |-> (wr_en && $onehot0(cmd_wr)));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !iack) |-> rd_data == '0);
endmodule

bind sio_regport sio_regport_chk #(
  .AW(AW), .DW(DW), .NCH(NCH), .VEC_ADDR(VEC_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .iack(iack), .pend_in(pend_in), .irq(irq), .done(done),
  .rd_data(rd_data), .vec_q(vec_q), .ien_q(ien_q), .cmd_wr(cmd_wr)
);

// File: tb/sio_regport_tb_top.sv
`timescale 1ns/1ps
module sio_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, iack = 1'b0, pend_in = 1'b0;
  logic [15:0] chan_status = 16'h3CA5;
  logic [7:0]  rd_data, cmd_data;
  logic        done, irq;
  logic [1:0]  cmd_wr;
  logic [15:0] cfg_mode, cfg_clksel;

  always #2.5 clk = ~clk;

  sio_regport dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .iack(iack), .pend_in(pend_in),
    .chan_status(chan_status), .rd_data(rd_data), .done(done), .irq(irq),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cfg_mode(cfg_mode),
    .cfg_clksel(cfg_clksel)
  );

  typedef struct {
    logic       d;
    logic [7:0] rd;
    logic       i;
    logic [1:0] cmd;
    logic [7:0] cd;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;

  // bench model of the register state
  logic [7:0] m_mode [2] = '{8'h00, 8'h00};
  logic [7:0] m_clks [2] = '{8'h00, 8'h00};
  logic [7:0] m_vec = 8'h0F;
  logic       m_ien = 1'b0;

  function automatic logic [7:0] model_rd(input logic [4:0] a);
    if (a == 5'h10) return m_vec;
    if (a == 5'h11) return {7'b0, m_ien};
    if (a < 5'd16) begin
      case (a[2:0])
        3'd0:    return m_mode[a[3]];
        3'd1:    return chan_status[a[3]*8 +: 8];
        3'd2:    return m_clks[a[3]];
        default: return 8'h00;
      endcase
    end
    return 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (q.size() != 0) begin
      e = q.pop_front();
      chk(e.req, "done", int'(done), int'(e.d));
      chk(e.req, "rd_data", int'(rd_data), int'(e.rd));
      chk(e.req, "irq", int'(irq), int'(e.i));
      chk(e.req, "cmd_wr", int'(cmd_wr), int'(e.cmd));
      if (e.cmd != 2'b00) chk(e.req, "cmd_data", int'(cmd_data), int'(e.cd));
    end
  end

  // driver: present one access and queue its expected results
  task automatic cyc(input logic r, input logic w, input logic ia,
                     input logic [4:0] a, input logic [7:0] d,
                     input logic p, input string req);
    exp_t x;
    logic irq_e;
    @(posedge clk); #1;
    rd_en = r; wr_en = w; iack = ia; addr = a; wr_data = d; pend_in = p;
    irq_e  = p & m_ien;
    x.i    = irq_e;
    x.d    = r | w | (ia & irq_e);
    x.rd   = (ia & irq_e) ? m_vec : (r ? model_rd(a) : 8'h00);
    x.cmd  = (w && a < 5'd16 && a[2:0] == 3'd3) ? (a[3] ? 2'b10 : 2'b01) : 2'b00;
    x.cd   = d;
    x.req  = req;
    q.push_back(x);
    if (w) begin
      if (a < 5'd16 && a[2:0] == 3'd0) m_mode[a[3]] = d;
      if (a < 5'd16 && a[2:0] == 3'd2) m_clks[a[3]] = d;
      if (a == 5'h10) m_vec = d;
      if (a == 5'h11) m_ien = d[0];
    end
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    cyc(1'b1, 1'b0, 1'b0, a, 8'h00, 1'b0, req);
  endtask
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
    cyc(1'b0, 1'b1, 1'b0, a, d, 1'b0, req);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, "R1"); rd(5'h0A, "R1"); rd(5'h10, "R1"); rd(5'h11, "R1");
    cyc(1'b0, 1'b0, 1'b0, 5'h00, 8'h00, 1'b1, "R1");
    // R2 idle cycle: no done
    cyc(1'b0, 1'b0, 1'b0, 5'h03, 8'h00, 1'b0, "R2");
    // R10 acknowledge while disabled
    cyc(1'b0, 1'b0, 1'b1, 5'h00, 8'h00, 1'b1, "R10");
    // R8 enable: only bit 0 kept, gating of pend_in
    wr(5'h11, 8'hFF, "R8"); rd(5'h11, "R8");
    cyc(1'b0, 1'b0, 1'b0, 5'h00, 8'h00, 1'b1, "R8");
    cyc(1'b0, 1'b0, 1'b0, 5'h00, 8'h00, 1'b0, "R8");
    // R11 acknowledge with unwritten vector
    cyc(1'b0, 1'b0, 1'b1, 5'h07, 8'h00, 1'b1, "R11");
    // R3 per-channel mode and clock select
    wr(5'h00, 8'h55, "R3"); wr(5'h0A, 8'h9A, "R3");
    rd(5'h00, "R3"); rd(5'h08, "R3"); rd(5'h02, "R3"); rd(5'h0A, "R3");
    wr(5'h08, 8'hC3, "R3"); rd(5'h08, "R3"); rd(5'h00, "R3");
    // R4 status read-only
    rd(5'h01, "R4"); rd(5'h09, "R4");
    wr(5'h01, 8'h00, "R4"); rd(5'h01, "R4"); rd(5'h00, "R4");
    // R5 command strobes
    wr(5'h0B, 8'h6E, "R5"); wr(5'h03, 8'h11, "R5"); rd(5'h0B, "R5");
    // R6 reserved locations
    rd(5'h05, "R6"); rd(5'h12, "R6"); rd(5'h1F, "R6");
    wr(5'h14, 8'hEE, "R6"); wr(5'h0C, 8'hEE, "R6"); wr(5'h04, 8'h77, "R6");
    rd(5'h00, "R6"); rd(5'h0A, "R6"); rd(5'h10, "R6"); rd(5'h11, "R6");
    // R7 vector register
    wr(5'h10, 8'h40, "R7"); rd(5'h10, "R7");
    // R9 acknowledge answered with vector
    cyc(1'b0, 1'b0, 1'b1, 5'h00, 8'h00, 1'b1, "R9");
    // R10 acknowledge after pend_in drops
    cyc(1'b0, 1'b0, 1'b1, 5'h00, 8'h00, 1'b0, "R10");
    // R2 write to reserved still completes
    wr(5'h1E, 8'h01, "R2");
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0; iack = 1'b0; pend_in = 1'b0;
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule